// File: doc/BRIEF.md
# Branch and Address Generation Unit

This unit forms effective addresses for a machine whose memory holds 65,536 words of 16 bits each, and it decides branches. A base value from a register is added to a signed offset. The offset is either a second register value or an 8-bit immediate that is sign-extended to 16 bits. The same sum serves loads, stores, register-indirect access (offset zero), absolute access and relative branch targets.

In the same cycle the unit checks the branch condition against the zero and negative status flags from the ALU. It selects the next program counter: the computed address when the branch is taken, otherwise the current PC plus one. All results are registered and appear one clock after the operands are presented. There is no handshake. Every clock edge outside reset accepts a new set of operands.

Top module: `branch_addr_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets `ea_o`, `next_pc_o` and `take_o` to zero.
- R2: `ea_o` equals (`base_i` + offset) modulo 65,536, registered one clock after the operands are sampled. A carry out of bit 15 is dropped and nothing reports it.
- R3: When `use_imm_i` is 1 the offset is `imm_i` sign-extended from bit 7, so 0x80..0xFF give -128..-1. When `use_imm_i` is 0 the offset is `off_reg_i` read as a 16-bit two's-complement value. The input that is not selected has no effect on `ea_o`.
- R4: A zero offset (register or immediate) gives `ea_o` equal to `base_i`.
- R5: With `cond_i` = 2'b00 (never), `take_o` is 0 whatever the flags are.
- R6: With `cond_i` = 2'b01 (on zero), `take_o` equals `zero_i`, and `neg_i` is ignored.
- R7: With `cond_i` = 2'b10 (on negative), `take_o` equals `neg_i`, and `zero_i` is ignored.
- R8: With `cond_i` = 2'b11 (always), `take_o` is 1 whatever the flags are.
- R9: `next_pc_o` equals `ea_o` when `take_o` is 1. Otherwise it equals (`pc_i` + 1) modulo 65,536, so 0xFFFF is followed by 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_i | input | 16 | Base register value |
| off_reg_i | input | 16 | Offset register value (two's complement) |
| imm_i | input | 8 | Immediate offset field (two's complement) |
| use_imm_i | input | 1 | 1 selects the immediate offset, 0 selects the register offset |
| cond_i | input | 2 | Branch condition: 00 never, 01 zero, 10 negative, 11 always |
| zero_i | input | 1 | ALU zero flag |
| neg_i | input | 1 | ALU negative flag |
| pc_i | input | 16 | Current program counter |
| ea_o | output | 16 | Registered effective address or branch target |
| take_o | output | 1 | Registered branch-taken decision |
| next_pc_o | output | 16 | Registered next program counter |

## Verification
All three results, `ea_o`, `take_o` and `next_pc_o`, are due exactly one rising edge after the operands are sampled. The bench drives operands on the falling edge and samples the outputs 1 ns after the following rising edge. It then compares them with values its own functions compute from the requirements. The reset check samples the same way, after an edge at which `rst_n` was low. Random operand sets are mixed with directed cases: sign-boundary immediates, address wrap, PC wrap, and each condition code paired with the flag values that should not matter to it.

// File: rtl/agu_pkg.sv
// Package: shared types for the branch and address generation unit.
// Assumes a two-bit condition select, with the encoding fixed by the
// instruction decoder that drives it.
package agu_pkg;

    typedef enum logic [1:0] {
        BR_NEVER  = 2'b00,
        BR_ZERO   = 2'b01,
        BR_NEG    = 2'b10,
        BR_ALWAYS = 2'b11
    } br_cond_e;

endpackage

// File: rtl/agu_offset_sel.sv
// Module: agu_offset_sel
// Picks the offset to add to the base: either a full-width register value
// or a narrow immediate that is sign-extended to full width.
// Assumes IMM_W < ADDR_W and two's-complement encoding on both inputs.
module agu_offset_sel #(
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic [ADDR_W-1:0] reg_off_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    output logic [ADDR_W-1:0] off_o
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;

    // Low bits of the extended immediate come straight from the field.
    assign imm_ext[IMM_W-1:0] = imm_i;

    // Replicate the immediate's sign bit into each upper bit.
    for (genvar g = 0; g < EXT_W; g++) begin : g_sext
        assign imm_ext[IMM_W+g] = imm_i[IMM_W-1];
    end

    // Choose the offset source.
    always_comb begin
        off_o = use_imm_i ? imm_ext : reg_off_i;
    end

endmodule

// File: rtl/agu_wrap_add.sv
// Module: agu_wrap_add
// Adds two operands of equal width modulo 2^W. The carry out is dropped,
// so nothing reports an overflow. The unit uses it both for base + offset
// and for PC + 1.
module agu_wrap_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    // Sum truncated to the operand width.
    always_comb begin
        sum_o = a_i + b_i;
    end

endmodule

// File: rtl/agu_cond_eval.sv
// Module: agu_cond_eval
// Decides whether a branch is taken from the condition select and the ALU
// status flags. Assumes the flags are valid in the same cycle as the select.
module agu_cond_eval
    import agu_pkg::*;
(
    input  logic [1:0] cond_i,
    input  logic       zero_i,
    input  logic       neg_i,
    output logic       take_o
);
    br_cond_e cond;

    // Map the raw select onto the condition type.
    always_comb begin
        cond = br_cond_e'(cond_i);
    end

    // Evaluate the selected condition.
    always_comb begin
        unique case (cond)
            BR_NEVER:  take_o = 1'b0;
            BR_ZERO:   take_o = zero_i;
            BR_NEG:    take_o = neg_i;
            BR_ALWAYS: take_o = 1'b1;
            default:   take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_addr_unit.sv
// Module: branch_addr_unit
// Top of the branch and address generation unit. It forms base + signed
// offset, evaluates the branch condition and selects the next PC. All three
// results are registered, with one clock of latency.
// Assumes a synchronous active-low reset and a new operand set each cycle.
module branch_addr_unit
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] off_reg_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic [1:0]        cond_i,
    input  logic              zero_i,
    input  logic              neg_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              take_o,
    output logic [ADDR_W-1:0] next_pc_o
);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] ea_d;
    logic [ADDR_W-1:0] pc_inc;
    logic              take_d;
    logic [ADDR_W-1:0] npc_d;
    logic              live_q;

    agu_offset_sel #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_off (
        .reg_off_i (off_reg_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .off_o     (offset)
    );

    agu_wrap_add #(.W(ADDR_W)) u_ea_add (
        .a_i   (base_i),
        .b_i   (offset),
        .sum_o (ea_d)
    );

    agu_wrap_add #(.W(ADDR_W)) u_pc_add (
        .a_i   (pc_i),
        .b_i   (PC_STEP),
        .sum_o (pc_inc)
    );

    agu_cond_eval u_cond (
        .cond_i (cond_i),
        .zero_i (zero_i),
        .neg_i  (neg_i),
        .take_o (take_d)
    );

    // Choose the branch target or the fall-through PC.
    always_comb begin
        npc_d = take_d ? ea_d : pc_inc;
    end

    // Register the results and clear them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_o      <= '0;
            take_o    <= 1'b0;
            next_pc_o <= '0;
        end else begin
            ea_o      <= ea_d;
            take_o    <= take_d;
            next_pc_o <= npc_d;
        end
    end

    // Mark that at least one operand set has been registered since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R9: a taken branch continues at the computed address.
    a_r9_taken_target: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        take_o |-> next_pc_o == ea_o);

    // R9: a branch not taken falls through to the PC plus one.
    a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        !take_o |-> next_pc_o == ADDR_W'($past(pc_i) + PC_STEP));

    // R5: the never code cannot take a branch.
    a_r5_never: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(cond_i) == 2'b00 |-> !take_o);

    // R8: the always code takes the branch.
    a_r8_always: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(cond_i) == 2'b11 |-> take_o);

    // R4: a zero register offset yields the base.
    a_r4_zero_reg: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(!use_imm_i && off_reg_i == '0) |-> ea_o == $past(base_i));

    // R4: a zero immediate yields the base.
    a_r4_zero_imm: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(use_imm_i && imm_i == '0) |-> ea_o == $past(base_i));

endmodule

// File: tb/branch_addr_unit_test.sv
`timescale 1ns/1ps
module branch_addr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base_i = '0, off_reg_i = '0, pc_i = '0;
    logic [7:0]  imm_i = '0;
    logic        use_imm_i = 1'b0, zero_i = 1'b0, neg_i = 1'b0;
    logic [1:0]  cond_i = 2'b00;
    logic [15:0] ea_o, next_pc_o;
    logic        take_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    branch_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .off_reg_i(off_reg_i),
        .imm_i(imm_i), .use_imm_i(use_imm_i), .cond_i(cond_i),
        .zero_i(zero_i), .neg_i(neg_i), .pc_i(pc_i),
        .ea_o(ea_o), .take_o(take_o), .next_pc_o(next_pc_o)
    );

    function automatic logic [15:0] exp_ea(logic [15:0] b, logic [15:0] r,
                                           logic [7:0] im, logic ui);
        logic [15:0] off;
        off = ui ? {{8{im[7]}}, im} : r;
        return b + off;
    endfunction

    function automatic logic exp_take(logic [1:0] c, logic z, logic n);
        case (c)
            2'b00:   return 1'b0;
            2'b01:   return z;
            2'b10:   return n;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one operand set on the falling edge and check the results that
    // are due one rising edge later.
    task automatic run(string tag, logic [15:0] b, logic [15:0] r, logic [7:0] im,
                       logic ui, logic [1:0] c, logic z, logic n, logic [15:0] pc);
        logic [15:0] e_ea;
        logic        e_tk;
        @(negedge clk);
        base_i = b; off_reg_i = r; imm_i = im; use_imm_i = ui;
        cond_i = c; zero_i = z; neg_i = n; pc_i = pc;
        e_ea = exp_ea(b, r, im, ui);
        e_tk = exp_take(c, z, n);
        @(posedge clk);
        #1;
        check16({tag, " ea"}, ea_o, e_ea);
        check1({tag, " take"}, take_o, e_tk);
        check16({tag, " next_pc"}, next_pc_o, e_tk ? e_ea : pc + 16'd1);
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: outputs are cleared by reset, even with busy inputs.
        base_i = 16'h1234; off_reg_i = 16'h0101; cond_i = 2'b11; pc_i = 16'h00ff;
        repeat (3) @(posedge clk);
        #1;
        check16("R1 ea", ea_o, 16'h0000);
        check1("R1 take", take_o, 1'b0);
        check16("R1 next_pc", next_pc_o, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: zero offsets give the base.
        run("R4 reg zero", 16'h4a5b, 16'h0000, 8'h77, 1'b0, 2'b00, 1'b0, 1'b0, 16'h0010);
        run("R4 imm zero", 16'hbeef, 16'h1111, 8'h00, 1'b1, 2'b00, 1'b1, 1'b1, 16'h0020);
        // R3: immediate sign boundaries; the unused register offset has no effect.
        run("R3 imm -1", 16'h1000, 16'h7777, 8'hff, 1'b1, 2'b11, 1'b0, 1'b0, 16'h0030);
        run("R3 imm -128", 16'h1000, 16'h5555, 8'h80, 1'b1, 2'b11, 1'b0, 1'b0, 16'h0040);
        run("R3 imm +127", 16'h1000, 16'h9999, 8'h7f, 1'b1, 2'b11, 1'b0, 1'b0, 16'h0050);
        run("R3 reg neg", 16'h0100, 16'hfff0, 8'h7f, 1'b0, 2'b11, 1'b0, 1'b0, 16'h0060);
        // R2: the address wraps with no side effect.
        run("R2 wrap up", 16'hffff, 16'h0002, 8'h00, 1'b0, 2'b11, 1'b0, 1'b0, 16'h0070);
        run("R2 wrap down", 16'h0000, 16'h0000, 8'hff, 1'b1, 2'b11, 1'b0, 1'b0, 16'h0080);
        // R5..R8: each condition code with flags that should not matter.
        run("R5 never flags set", 16'h2000, 16'h0004, 8'h00, 1'b0, 2'b00, 1'b1, 1'b1, 16'h0100);
        run("R6 zero set", 16'h2000, 16'h0004, 8'h00, 1'b0, 2'b01, 1'b1, 1'b0, 16'h0100);
        run("R6 zero clr neg set", 16'h2000, 16'h0004, 8'h00, 1'b0, 2'b01, 1'b0, 1'b1, 16'h0100);
        run("R7 neg set", 16'h3000, 16'h0000, 8'hfe, 1'b1, 2'b10, 1'b0, 1'b1, 16'h0200);
        run("R7 neg clr zero set", 16'h3000, 16'h0000, 8'hfe, 1'b1, 2'b10, 1'b1, 1'b0, 16'h0200);
        run("R8 always no flags", 16'h4000, 16'h0000, 8'h05, 1'b1, 2'b11, 1'b0, 1'b0, 16'h0300);
        // R9: the fall-through PC wraps.
        run("R9 pc wrap", 16'h5000, 16'h0001, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 16'hffff);

        // Random mix, R2 R3 R5 R6 R7 R8 R9.
        for (int i = 0; i < 400; i++) begin
            run("R2/R9 random", 16'($urandom), 16'($urandom), 8'($urandom),
                1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule